// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns the virtual address of a processor load, store or instruction fetch into a physical address under single-level paging. The low bits of the address are the offset within a page and pass through unchanged. The high bits are the virtual page number, and they are replaced by a physical page number. A small fully associative translation cache answers most requests in one cycle. When the cache misses, a hardware walker reads one page-table entry from memory. The address of that entry is a programmable base plus the page number times four bytes. The walker checks the entry, returns the result and, if the entry is usable, installs it in the cache.

Every request carries its access type. Each page-table entry has a valid bit and a rights field. An entry that is not valid produces a page fault. An access that the rights do not permit produces a protection fault. Loading a new table base switches to another mapping and drops every cached translation.

Top module: `page_xlat`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, mem_req_o is 0 and the translation cache is empty, so the first access always walks.
- R2: The page offset is vaddr[9:0] and the virtual page number is vaddr[14:10]. On success, paddr[9:0] equals the request's offset.
- R3: A request that hits the cache gives rsp_valid_o in the cycle after acceptance and issues no memory read.
- R4: A miss issues exactly one memory read at base + page*4. mem_req_o stays high with a stable address until mem_rvalid_i. req_ready_o stays low from acceptance until the read returns, and the response follows one cycle after the read data.
- R5: The entry word has bit 0 = valid, bits 2:1 = rights (00 read-only, 01 read/write, 10 execute, 11 read/write/execute) and bits 5:3 = physical page number. On success, paddr = {page number, offset}.
- R6: An entry with valid = 0 raises rsp_page_fault_o with paddr 0 and no protection fault.
- R7: req_kind_i is 00 load, 01 store, 10 fetch, and 11 is treated as a load. Loads are allowed on any valid page. A store needs rights 01 or 11 and a fetch needs rights 10 or 11. Any other combination raises rsp_prot_fault_o with paddr 0.
- R8: A faulting entry is never installed, so the next access to that page walks again. A rights violation on a cached entry is reported without a memory read.
- R9: The cache has 4 fully associative entries. A fill takes an empty entry if one exists, and otherwise the least recently used entry. Both hits (faulting hits included) and fills count as uses.
- R10: A base write invalidates every cached entry. req_ready_o is low in any cycle where base_we_i is high.
- R11: If the base is written while a walk is in flight, that walk's result is still returned but it is not installed.
- R12: Each accepted request gets exactly one single-cycle response, and the two fault flags are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_vaddr_i | input | 15 | Virtual address |
| req_kind_i | input | 2 | Access type: 00 load, 01 store, 10 fetch |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_paddr_o | output | 13 | Physical address, 0 on a fault |
| rsp_page_fault_o | output | 1 | Entry not valid |
| rsp_prot_fault_o | output | 1 | Access not permitted by rights |
| mem_req_o | output | 1 | Entry read request, held until data |
| mem_addr_o | output | 32 | Byte address of the page-table entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Page-table entry word |
| base_we_i | input | 1 | Load a new table base |
| base_wdata_i | input | 32 | New table base byte address |

## Verification
Some properties are checked on every cycle. A hit answers in the next cycle with no memory traffic. A pending walk holds its request and address steady and keeps the request port closed. The offset survives translation. Faults zero the address and never both assert. There is one response per accepted request. The age state always has exactly one oldest entry. Other behaviours appear only in the bench's scenarios: the actual mapping from entry contents to addresses and faults, the order in which entries are evicted, the refusal to cache faulting entries, the flush on a base write, and the discarding of a walk that a base write made stale.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_STORE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_ALT   = 2'b11
  } kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_e;

  // rights: bit0 = writable, bit1 = executable; all valid pages readable
  function automatic logic rights_ok(input logic [1:0] kind, input logic [1:0] rights);
    case (kind)
      KIND_STORE: rights_ok = rights[0];
      KIND_FETCH: rights_ok = rights[1];
      default:    rights_ok = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  input  logic [N-1:0]  valid_i,
  output logic [IW-1:0] victim_o,
  output logic [N-1:0]  oldest_o
);
  localparam logic [IW-1:0] AGE_MAX = IW'(N - 1);

  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx_i)              age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_o[g] = (age_q[g] == AGE_MAX);
  end

  // empty slot first, else the oldest
  always_comb begin
    logic found;
    victim_o = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!valid_i[i] && !found) begin
        victim_o = IW'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (oldest_o[i]) victim_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int N     = 4,
  parameter int VPN_W = 5,
  parameter int PPN_W = 3,
  parameter int IW    = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lookup_vpn_i,
  output logic             hit_o,
  output logic [IW-1:0]    hit_idx_o,
  output logic [1:0]       hit_rights_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  input  logic             fill_i,
  input  logic [IW-1:0]    fill_idx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [1:0]       fill_rights_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  output logic [N-1:0]     valid_o
);
  logic [N-1:0]     vld_q;
  logic [VPN_W-1:0] vpn_q    [N];
  logic [1:0]       rights_q [N];
  logic [PPN_W-1:0] ppn_q    [N];
  logic [N-1:0]     match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        vpn_q[i]    <= '0;
        rights_q[i] <= '0;
        ppn_q[i]    <= '0;
      end
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (fill_i) begin
      vld_q[fill_idx_i]    <= 1'b1;
      vpn_q[fill_idx_i]    <= fill_vpn_i;
      rights_q[fill_idx_i] <= fill_rights_i;
      ppn_q[fill_idx_i]    <= fill_ppn_i;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (vpn_q[g] == lookup_vpn_i);
  end

  always_comb begin
    hit_idx_o    = '0;
    hit_rights_o = '0;
    hit_ppn_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit_idx_o    = IW'(i);
        hit_rights_o = rights_q[i];
        hit_ppn_o    = ppn_q[i];
      end
    end
  end

  assign hit_o   = |match;
  assign valid_o = vld_q;
endmodule

// File: rtl/page_xlat.sv
module page_xlat
  import page_xlat_pkg::*;
#(
  parameter int VA_W    = 15,
  parameter int PA_W    = 13,
  parameter int PAGE_W  = 10,
  parameter int TLB_N   = 4,
  parameter int MADDR_W = 32,
  parameter int MDATA_W = 32,
  parameter int PTE_B   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic [1:0]         req_kind_i,
  output logic               rsp_valid_o,
  output logic [PA_W-1:0]    rsp_paddr_o,
  output logic               rsp_page_fault_o,
  output logic               rsp_prot_fault_o,
  output logic               mem_req_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [MDATA_W-1:0] mem_rdata_i,
  input  logic               base_we_i,
  input  logic [MADDR_W-1:0] base_wdata_i
);
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PPN_W  = PA_W - PAGE_W;
  localparam int IW     = $clog2(TLB_N);
  localparam int PTE_SH = $clog2(PTE_B);
  localparam int PPN_LO = 3;

  walk_state_e        state_q;
  logic [MADDR_W-1:0] base_q;
  logic [MADDR_W-1:0] wk_addr_q;
  logic [VPN_W-1:0]   wk_vpn_q;
  logic [PAGE_W-1:0]  wk_off_q;
  logic [1:0]         wk_kind_q;
  logic               stale_q;

  logic               rsp_valid_q, rsp_pf_q, rsp_prf_q;
  logic [PA_W-1:0]    rsp_pa_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [PAGE_W-1:0]  lk_off;
  logic               fire, hit_w, hit_ok;
  logic [IW-1:0]      hit_idx, victim, touch_idx;
  logic [1:0]         hit_rights;
  logic [PPN_W-1:0]   hit_ppn;
  logic [TLB_N-1:0]   tlb_valid, lru_oldest;

  logic               rd_done, pte_v, pte_ok, fill_w, touch_w;
  logic [1:0]         pte_r;
  logic [PPN_W-1:0]   pte_ppn;
  logic               unused_rdata;

  assign lk_vpn      = req_vaddr_i[VA_W-1:PAGE_W];
  assign lk_off      = req_vaddr_i[PAGE_W-1:0];
  assign req_ready_o = (state_q == ST_IDLE) && !base_we_i;
  assign fire        = req_valid_i && req_ready_o;
  assign hit_ok      = rights_ok(req_kind_i, hit_rights);

  assign rd_done = (state_q == ST_WALK) && mem_rvalid_i;
  assign pte_v   = mem_rdata_i[0];
  assign pte_r   = mem_rdata_i[2:1];
  assign pte_ppn = mem_rdata_i[PPN_LO +: PPN_W];
  assign pte_ok  = rights_ok(wk_kind_q, pte_r);
  assign unused_rdata = ^mem_rdata_i[MDATA_W-1:PPN_LO+PPN_W];

  // stale walks and faulting entries are not cached
  assign fill_w    = rd_done && pte_v && pte_ok && !stale_q && !base_we_i;
  assign touch_w   = (fire && hit_w) || fill_w;
  assign touch_idx = fill_w ? victim : hit_idx;

  xlat_cam #(.N(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (base_we_i),
    .lookup_vpn_i (lk_vpn),
    .hit_o        (hit_w),
    .hit_idx_o    (hit_idx),
    .hit_rights_o (hit_rights),
    .hit_ppn_o    (hit_ppn),
    .fill_i       (fill_w),
    .fill_idx_i   (victim),
    .fill_vpn_i   (wk_vpn_q),
    .fill_rights_i(pte_r),
    .fill_ppn_i   (pte_ppn),
    .valid_o      (tlb_valid)
  );

  xlat_lru #(.N(TLB_N)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch_w),
    .touch_idx_i (touch_idx),
    .valid_i     (tlb_valid),
    .victim_o    (victim),
    .oldest_o    (lru_oldest)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      wk_addr_q   <= '0;
      wk_vpn_q    <= '0;
      wk_off_q    <= '0;
      wk_kind_q   <= '0;
      stale_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_pa_q    <= '0;
      rsp_pf_q    <= 1'b0;
      rsp_prf_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (base_we_i) begin
        base_q  <= base_wdata_i;
        stale_q <= 1'b1;
      end
      if (fire && hit_w) begin
        rsp_valid_q <= 1'b1;
        rsp_pf_q    <= 1'b0;
        rsp_prf_q   <= !hit_ok;
        rsp_pa_q    <= hit_ok ? {hit_ppn, lk_off} : '0;
      end else if (fire) begin
        state_q   <= ST_WALK;
        wk_vpn_q  <= lk_vpn;
        wk_off_q  <= lk_off;
        wk_kind_q <= req_kind_i;
        wk_addr_q <= base_q + (MADDR_W'(lk_vpn) << PTE_SH);
        stale_q   <= 1'b0;
      end
      if (rd_done) begin
        state_q     <= ST_IDLE;
        rsp_valid_q <= 1'b1;
        rsp_pf_q    <= !pte_v;
        rsp_prf_q   <= pte_v && !pte_ok;
        rsp_pa_q    <= (pte_v && pte_ok) ? {pte_ppn, wk_off_q} : '0;
      end
    end
  end

  assign mem_req_o        = (state_q == ST_WALK);
  assign mem_addr_o       = wk_addr_q;
  assign rsp_valid_o      = rsp_valid_q;
  assign rsp_paddr_o      = rsp_pa_q;
  assign rsp_page_fault_o = rsp_pf_q;
  assign rsp_prot_fault_o = rsp_prf_q;
endmodule

// File: rtl/page_xlat_chk.sv
module page_xlat_chk #(
  parameter int PA_W    = 13,
  parameter int PAGE_W  = 10,
  parameter int TLB_N   = 4,
  parameter int MADDR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [PAGE_W-1:0]  req_off_i,
  input logic               rsp_valid_o,
  input logic [PA_W-1:0]    rsp_paddr_o,
  input logic               rsp_page_fault_o,
  input logic               rsp_prot_fault_o,
  input logic               mem_req_o,
  input logic [MADDR_W-1:0] mem_addr_o,
  input logic               mem_rvalid_i,
  input logic               base_we_i,
  input logic               lookup_hit,
  input logic [TLB_N-1:0]   lru_oldest
);
  logic              fire;
  logic              pend_q;
  logic [PAGE_W-1:0] off_q;

  assign fire = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      off_q  <= '0;
    end else begin
      if (fire) begin
        pend_q <= 1'b1;
        off_q  <= req_off_i;
      end else if (rsp_valid_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && lookup_hit |=> rsp_valid_o); // R3
  AST_HIT_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && lookup_hit |=> !mem_req_o); // R3
  AST_WALK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R4
  AST_READ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)); // R4
  AST_READ_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> pend_q); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_page_fault_o && !rsp_prot_fault_o |-> rsp_paddr_o[PAGE_W-1:0] == off_q); // R2
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_page_fault_o || rsp_prot_fault_o) |-> rsp_paddr_o == '0); // R6
  AST_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_page_fault_o && rsp_prot_fault_o)); // R12
  AST_ONE_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> pend_q); // R12
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> !pend_q || rsp_valid_o); // R12
  AST_ONE_OLDEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lru_oldest) == 1); // R9
  AST_BASE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_i |-> !req_ready_o); // R10
endmodule

bind page_xlat page_xlat_chk #(
  .PA_W(PA_W), .PAGE_W(PAGE_W), .TLB_N(TLB_N), .MADDR_W(MADDR_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_ready_o      (req_ready_o),
  .req_off_i        (req_vaddr_i[PAGE_W-1:0]),
  .rsp_valid_o      (rsp_valid_o),
  .rsp_paddr_o      (rsp_paddr_o),
  .rsp_page_fault_o (rsp_page_fault_o),
  .rsp_prot_fault_o (rsp_prot_fault_o),
  .mem_req_o        (mem_req_o),
  .mem_addr_o       (mem_addr_o),
  .mem_rvalid_i     (mem_rvalid_i),
  .base_we_i        (base_we_i),
  .lookup_hit       (hit_w),
  .lru_oldest       (lru_oldest)
);

// File: tb/tb_page_xlat.sv
module tb_page_xlat;
  localparam int CLK_P = 10;
  localparam int NVEC  = 20;

  typedef struct packed {
    logic [14:0] va;
    logic [1:0]  kind;
    logic        pf;
    logic        prf;
    logic [12:0] pa;
    logic        walk;
  } vec_t;

  // base 0: p0 RW->5, p1 RO->2, p2 X->7, p3 invalid, p4 RWX->1, p31 RO->3
  localparam vec_t VEC [NVEC] = '{
    '{15'h0123, 2'd0, 1'b0, 1'b0, 13'h1523, 1'b1},
    '{15'h03FF, 2'd0, 1'b0, 1'b0, 13'h17FF, 1'b0},
    '{15'h0001, 2'd1, 1'b0, 1'b0, 13'h1401, 1'b0},
    '{15'h0410, 2'd1, 1'b0, 1'b1, 13'h0000, 1'b1},
    '{15'h0410, 2'd1, 1'b0, 1'b1, 13'h0000, 1'b1},
    '{15'h0420, 2'd0, 1'b0, 1'b0, 13'h0820, 1'b1},
    '{15'h0420, 2'd1, 1'b0, 1'b1, 13'h0000, 1'b0},
    '{15'h0804, 2'd2, 1'b0, 1'b0, 13'h1C04, 1'b1},
    '{15'h0808, 2'd0, 1'b0, 1'b0, 13'h1C08, 1'b0},
    '{15'h0000, 2'd2, 1'b0, 1'b1, 13'h0000, 1'b0},
    '{15'h0C00, 2'd0, 1'b1, 1'b0, 13'h0000, 1'b1},
    '{15'h0C10, 2'd0, 1'b1, 1'b0, 13'h0000, 1'b1},
    '{15'h13FF, 2'd2, 1'b0, 1'b0, 13'h07FF, 1'b1},
    '{15'h7C00, 2'd0, 1'b0, 1'b0, 13'h0C00, 1'b1},
    '{15'h0000, 2'd0, 1'b0, 1'b0, 13'h1400, 1'b0},
    '{15'h0400, 2'd0, 1'b0, 1'b0, 13'h0800, 1'b1},
    '{15'h1000, 2'd0, 1'b0, 1'b0, 13'h0400, 1'b0},
    '{15'h0800, 2'd0, 1'b0, 1'b0, 13'h1C00, 1'b1},
    '{15'h7C00, 2'd0, 1'b0, 1'b0, 13'h0C00, 1'b1},
    '{15'h1005, 2'd0, 1'b0, 1'b0, 13'h0405, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [14:0] req_vaddr_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic        rsp_valid_o;
  logic [12:0] rsp_paddr_o;
  logic        rsp_page_fault_o, rsp_prot_fault_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        base_we_i = 1'b0;
  logic [31:0] base_wdata_i = '0;

  page_xlat dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mem [0:127];
  int walks = 0, cnt = 0;
  bit busy = 0;
  logic [31:0] last_addr = '0;

  // memory: two-cycle read latency, counts walks
  always @(negedge clk_i) begin
    if (mem_rvalid_i) mem_rvalid_i = 1'b0;
    else if (busy) begin
      cnt--;
      if (cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem[mem_addr_o[8:2]];
        busy = 0;
      end
    end else if (mem_req_o) begin
      busy = 1; cnt = 2; walks++; last_addr = mem_addr_o;
    end
  end

  function automatic logic [31:0] pte(input logic v, input logic [1:0] r, input logic [2:0] ppn);
    return {26'd0, ppn, r, v};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic access(input logic [14:0] va, input logic [1:0] k,
                        output logic pf, output logic prf, output logic [12:0] pa,
                        output int lat, output bit rdy_bad);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_kind_i = k;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 1; rdy_bad = 0;
    while (!rsp_valid_o && lat < 64) begin
      if (req_ready_o) rdy_bad = 1;
      @(negedge clk_i);
      lat++;
    end
    pf = rsp_page_fault_o; prf = rsp_prot_fault_o; pa = rsp_paddr_o;
    @(negedge clk_i);
    chk(!rsp_valid_o, "R12 single response pulse", 32'(rsp_valid_o), 0);
  endtask

  task automatic run_vec(input vec_t v, input logic [31:0] base);
    logic pf, prf;
    logic [12:0] pa;
    int lat, w0;
    bit rdy_bad;
    w0 = walks;
    access(v.va, v.kind, pf, prf, pa, lat, rdy_bad);
    chk(pf == v.pf, "R6 page fault", 32'(pf), 32'(v.pf));
    chk(prf == v.prf, "R7 protection fault", 32'(prf), 32'(v.prf));
    chk(pa == v.pa, "R5 R2 physical address", 32'(pa), 32'(v.pa));
    chk((walks - w0) == int'(v.walk), "R9 R8 walk count", 32'(walks - w0), 32'(v.walk));
    if (!v.walk) chk(lat == 1, "R3 hit latency", 32'(lat), 1);
    else begin
      chk(!rdy_bad, "R4 ready low during walk", 32'(rdy_bad), 0);
      chk(last_addr == base + {25'd0, v.va[14:10], 2'b00}, "R4 entry address",
          last_addr, base + {25'd0, v.va[14:10], 2'b00});
    end
  endtask

  task automatic wr_base(input logic [31:0] b);
    @(negedge clk_i);
    base_we_i = 1'b1; base_wdata_i = b;
    #1 chk(!req_ready_o, "R10 ready low on base write", 32'(req_ready_o), 0);
    @(negedge clk_i);
    base_we_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mem[0]  = pte(1'b1, 2'b01, 3'd5);
    mem[1]  = pte(1'b1, 2'b00, 3'd2);
    mem[2]  = pte(1'b1, 2'b10, 3'd7);
    mem[4]  = pte(1'b1, 2'b11, 3'd1);
    mem[31] = pte(1'b1, 2'b00, 3'd3);
    mem[64] = pte(1'b1, 2'b00, 3'd6);
    mem[65] = pte(1'b1, 2'b01, 3'd4);

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o, "R1 reset ready", 32'(req_ready_o), 1);
    chk(!rsp_valid_o, "R1 reset rsp_valid", 32'(rsp_valid_o), 0);
    chk(!mem_req_o, "R1 reset mem_req", 32'(mem_req_o), 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i], 32'h0);

    // R10: switch base, cache flushed, new table used
    wr_base(32'h100);
    run_vec('{15'h0055, 2'd0, 1'b0, 1'b0, 13'h1855, 1'b1}, 32'h100);
    run_vec('{15'h0055, 2'd1, 1'b0, 1'b1, 13'h0000, 1'b0}, 32'h100);
    run_vec('{15'h1000, 2'd0, 1'b1, 1'b0, 13'h0000, 1'b1}, 32'h100);

    // R11: base written mid-walk
    begin
      int n;
      int w0;
      @(negedge clk_i);
      req_valid_i = 1'b1; req_vaddr_i = 15'h0407; req_kind_i = 2'd0;
      while (!req_ready_o) @(negedge clk_i);
      @(negedge clk_i);
      req_valid_i = 1'b0;
      base_we_i = 1'b1; base_wdata_i = 32'h0;
      @(negedge clk_i);
      base_we_i = 1'b0;
      n = 0;
      while (!rsp_valid_o && n < 64) begin @(negedge clk_i); n++; end
      chk(rsp_paddr_o == 13'h1007, "R11 in-flight walk result", 32'(rsp_paddr_o), 32'h1007);
      w0 = walks;
      run_vec('{15'h0407, 2'd0, 1'b0, 1'b0, 13'h0807, 1'b1}, 32'h0);
      chk(walks - w0 == 1, "R11 stale entry not installed", 32'(walks - w0), 1);
    end

    // R7: kind 11 behaves as load on a read-only page
    run_vec('{15'h0408, 2'd3, 1'b0, 1'b0, 13'h0808, 1'b0}, 32'h0);

    finish_run();
  end
endmodule